// File: doc/BRIEF.md
# Fail-first vector length truncation unit

This unit sits beside a vector loop that issues one element per step. While fail-first mode is selected and the instruction updates its condition field, the unit looks at the 4-bit condition field produced by each element. It picks one bit of that field and may invert it. If the result shows a failure, the unit shortens the vector length so that later elements are dropped. Optionally the shortened length can still include the failing element.

The decoded mode fields come in on the ports: mode code, invert flag, bit select, the override that forces a condition update, and the inclusive flag. So do the instruction's own Rc bit and its Rc kind. The override lets an instruction with Rc clear still update and test its condition field, and in that case the test always uses the equality bit. The loop marks the start of each instruction with a pulse that loads the incoming vector length. The shortened length and a one-cycle truncate strobe come out registered, one cycle after the failing element.

Top module: `ffvl_unit`

## Requirements
- R1: Truncation can occur only when `mode_i` equals 2'd1 (fail-first) and `crupd_o` is high in the same cycle as the element.
- R2: `crupd_o` is combinational. Rc kind encodings: 0 = none, 1 = normal, 2 = forced to one, 3 = treated as none. `crupd_o` is high when the kind is normal and `rc_i` is 1. It is also high when `rc1_i` is 1 and either the kind is normal with `rc_i` 0, or the kind is forced. Otherwise it is low.
- R3: When the kind is normal and `rc_i` is 1, the tested bit is `crf_i[crsel_i]`, and both `rc1_i` and `incl_i` have no effect.
- R4: In every other case the tested bit is `crf_i[2]` (equality), whatever `crsel_i` holds, and `incl_i` is honoured.
- R5: An element fails when its tested bit differs from `inv_i`: a set bit fails with `inv_i` = 0, and a clear bit fails with `inv_i` = 1.
- R6: A failing element at step s with `elem_valid_i` high raises `trunc_o` for exactly the next cycle and sets `vl_o` to s. With the inclusive flag in effect, `vl_o` becomes s+1, saturating at 127. Elements with `elem_valid_i` low have no effect.
- R7: One cycle after `start_i`, `vl_o` equals the `vl_i` sampled with it. At all other times `vl_o` changes only on a truncation.
- R8: After a truncation, further elements are ignored until the next `start_i`. When `start_i` and an element arrive in the same cycle, `start_i` wins and that element is ignored.
- R9: During and right after reset, `vl_o` is 0 and `trunc_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Mode code, 1 selects fail-first |
| inv_i | input | 1 | Invert the sense of the bit test |
| crsel_i | input | 2 | Index of the tested bit when Rc is 1 |
| rc1_i | input | 1 | Force a condition update when Rc is 0 |
| incl_i | input | 1 | Keep the failing element in the new length |
| rc_i | input | 1 | Instruction's Rc bit |
| rc_kind_i | input | 2 | Rc kind of the instruction |
| start_i | input | 1 | Start of instruction, loads `vl_i` |
| vl_i | input | 7 | Vector length at instruction start |
| elem_valid_i | input | 1 | An element result is presented |
| step_i | input | 7 | Step index of the presented element |
| crf_i | input | 4 | Condition field of the presented element |
| vl_o | output | 7 | Current (possibly truncated) vector length |
| trunc_o | output | 1 | One-cycle strobe after a truncation |
| crupd_o | output | 1 | Condition-field update enable |

## Verification
The bench builds the unit with its default parameters: 7-bit lengths, a 4-bit condition field and the equality bit at index 2. With these values the saturation case at step 127 can be reached directly, and the select input can cover every bit position of the field. Every Rc kind is driven with and without the override, under both invert senses. A reference model compares the unit on every clock during directed scenarios and a long randomized run with random starts.

// File: rtl/ffvl_pkg.sv
package ffvl_pkg;
  localparam logic [1:0] MODE_FAILFIRST = 2'd1;

  localparam logic [1:0] RCK_NONE   = 2'd0;
  localparam logic [1:0] RCK_NORMAL = 2'd1;
  localparam logic [1:0] RCK_FORCED = 2'd2;
  localparam logic [1:0] RCK_RSVD   = 2'd3;
endpackage

// File: rtl/ffvl_decode.sv
// Resolves the effective update enable, tested-bit index and inclusive flag.
module ffvl_decode
  import ffvl_pkg::*;
#(
  parameter int SEL_W  = 2,
  parameter int EQ_IDX = 2
) (
  input  logic             rc_i,
  input  logic [1:0]       rc_kind_i,
  input  logic             rc1_i,
  input  logic             incl_i,
  input  logic [SEL_W-1:0] crsel_i,
  output logic             upd_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             incl_o
);
  localparam logic [SEL_W-1:0] EQ_SEL = SEL_W'(EQ_IDX);

  logic rc_eff;
  logic rc1_allowed;

  always_comb begin
    rc_eff      = (rc_kind_i == RCK_NORMAL) && rc_i;
    rc1_allowed = ((rc_kind_i == RCK_NORMAL) && !rc_i) || (rc_kind_i == RCK_FORCED);
    if (rc_eff) begin
      upd_o  = 1'b1;
      sel_o  = crsel_i;
      incl_o = 1'b0;
    end else begin
      upd_o  = rc1_i && rc1_allowed;
      sel_o  = EQ_SEL;
      incl_o = incl_i;
    end
  end
endmodule

// File: rtl/ffvl_crtest.sv
// Per-bit failure vector of the condition field, then selection.
module ffvl_crtest #(
  parameter int CRF_W = 4,
  parameter int SEL_W = 2
) (
  input  logic [CRF_W-1:0] crf_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             inv_i,
  output logic             fail_o
);
  logic [CRF_W-1:0] bit_fail;

  for (genvar g = 0; g < CRF_W; g++) begin : g_bit
    assign bit_fail[g] = crf_i[g] ^ inv_i;
  end

  assign fail_o = bit_fail[sel_i];
endmodule

// File: rtl/ffvl_trunc.sv
// Length register, halt flag and truncate strobe.
module ffvl_trunc #(
  parameter int VL_W = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [VL_W-1:0] vl_i,
  input  logic            elem_valid_i,
  input  logic            active_i,
  input  logic            fail_i,
  input  logic            incl_i,
  input  logic [VL_W-1:0] step_i,
  output logic [VL_W-1:0] vl_o,
  output logic            trunc_o
);
  localparam logic [VL_W-1:0] VL_MAX = {VL_W{1'b1}};

  logic [VL_W-1:0] vl_q, vl_d, new_vl;
  logic            halt_q, halt_d;
  logic            trunc_q, trunc_d;
  logic            hit;
  logic            st_en;

  always_comb begin
    hit = elem_valid_i && active_i && fail_i && !halt_q && !start_i;
    if (!incl_i)               new_vl = step_i;
    else if (step_i == VL_MAX) new_vl = VL_MAX;
    else                       new_vl = step_i + 1'b1;

    vl_d    = vl_q;
    halt_d  = halt_q;
    trunc_d = 1'b0;
    if (start_i) begin
      vl_d   = vl_i;
      halt_d = 1'b0;
    end else if (hit) begin
      vl_d    = new_vl;
      halt_d  = 1'b1;
      trunc_d = 1'b1;
    end
    st_en = start_i || hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vl_q   <= '0;
      halt_q <= 1'b0;
    end else if (st_en) begin
      vl_q   <= vl_d;
      halt_q <= halt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trunc_q <= 1'b0;
    else        trunc_q <= trunc_d;
  end

  assign vl_o    = vl_q;
  assign trunc_o = trunc_q;
endmodule

// File: rtl/ffvl_unit.sv
module ffvl_unit
  import ffvl_pkg::*;
#(
  parameter  int VL_W   = 7,
  parameter  int CRF_W  = 4,
  parameter  int EQ_IDX = 2,
  localparam int SEL_W  = $clog2(CRF_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_i,
  input  logic             inv_i,
  input  logic [SEL_W-1:0] crsel_i,
  input  logic             rc1_i,
  input  logic             incl_i,
  input  logic             rc_i,
  input  logic [1:0]       rc_kind_i,
  input  logic             start_i,
  input  logic [VL_W-1:0]  vl_i,
  input  logic             elem_valid_i,
  input  logic [VL_W-1:0]  step_i,
  input  logic [CRF_W-1:0] crf_i,
  output logic [VL_W-1:0]  vl_o,
  output logic             trunc_o,
  output logic             crupd_o
);
  logic             upd;
  logic [SEL_W-1:0] sel;
  logic             incl_eff;
  logic             fail;
  logic             active;

  ffvl_decode #(.SEL_W(SEL_W), .EQ_IDX(EQ_IDX)) u_decode (
    .rc_i      (rc_i),
    .rc_kind_i (rc_kind_i),
    .rc1_i     (rc1_i),
    .incl_i    (incl_i),
    .crsel_i   (crsel_i),
    .upd_o     (upd),
    .sel_o     (sel),
    .incl_o    (incl_eff)
  );

  ffvl_crtest #(.CRF_W(CRF_W), .SEL_W(SEL_W)) u_crtest (
    .crf_i  (crf_i),
    .sel_i  (sel),
    .inv_i  (inv_i),
    .fail_o (fail)
  );

  assign active  = (mode_i == MODE_FAILFIRST) && upd;
  assign crupd_o = upd;

  ffvl_trunc #(.VL_W(VL_W)) u_trunc (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .vl_i         (vl_i),
    .elem_valid_i (elem_valid_i),
    .active_i     (active),
    .fail_i       (fail),
    .incl_i       (incl_eff),
    .step_i       (step_i),
    .vl_o         (vl_o),
    .trunc_o      (trunc_o)
  );
endmodule

// File: rtl/ffvl_unit_chk.sv
module ffvl_unit_chk
  import ffvl_pkg::*;
#(
  parameter int VL_W = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      mode_i,
  input logic [1:0]      rc_kind_i,
  input logic            start_i,
  input logic [VL_W-1:0] vl_i,
  input logic            elem_valid_i,
  input logic [VL_W-1:0] vl_o,
  input logic            trunc_o,
  input logic            crupd_o
);
  // R1
  trunc_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trunc_o) |-> ($past(mode_i) == MODE_FAILFIRST) && $past(crupd_o));

  // R6
  trunc_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trunc_o) |-> $past(elem_valid_i) && !$past(start_i));

  // R8
  single_trunc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trunc_o |=> !trunc_o);

  // R7
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (vl_o == $past(vl_i)) && !trunc_o);

  // R7
  vl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !elem_valid_i) |=> $stable(vl_o));

  // R2
  no_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rc_kind_i == RCK_NONE) || (rc_kind_i == RCK_RSVD)) |-> !crupd_o);
endmodule

bind ffvl_unit ffvl_unit_chk #(.VL_W(VL_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode_i       (mode_i),
  .rc_kind_i    (rc_kind_i),
  .start_i      (start_i),
  .vl_i         (vl_i),
  .elem_valid_i (elem_valid_i),
  .vl_o         (vl_o),
  .trunc_o      (trunc_o),
  .crupd_o      (crupd_o)
);

// File: tb/ffvl_unit_tb.sv
`timescale 1ns/1ps
module ffvl_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_i = '0;
  logic       inv_i = 1'b0;
  logic [1:0] crsel_i = '0;
  logic       rc1_i = 1'b0;
  logic       incl_i = 1'b0;
  logic       rc_i = 1'b0;
  logic [1:0] rc_kind_i = '0;
  logic       start_i = 1'b0;
  logic [6:0] vl_i = '0;
  logic       elem_valid_i = 1'b0;
  logic [6:0] step_i = '0;
  logic [3:0] crf_i = '0;
  logic [6:0] vl_o;
  logic       trunc_o;
  logic       crupd_o;

  int checks = 0;
  int errors = 0;
  string cur_req = "R9";
  bit live = 1'b0;

  int r_vl = 0;
  bit r_halt = 1'b0;
  bit r_trunc = 1'b0;

  always #2.5 clk = ~clk;

  ffvl_unit u_dut (.*);

  function automatic bit exp_upd();
    bit rce = (rc_kind_i == 2'd1) && rc_i;
    return rce || (rc1_i && ((rc_kind_i == 2'd1 && !rc_i) || rc_kind_i == 2'd2));
  endfunction

  // reference model, behavioural
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_vl = 0; r_halt = 1'b0; r_trunc = 1'b0;
    end else begin
      bit rce;
      int idx;
      bit inc;
      bit failb;
      rce   = (rc_kind_i == 2'd1) && rc_i;
      idx   = rce ? int'(crsel_i) : 2;
      inc   = rce ? 1'b0 : incl_i;
      failb = crf_i[idx] != inv_i;
      r_trunc = 1'b0;
      if (start_i) begin
        r_vl = int'(vl_i); r_halt = 1'b0;
      end else if (elem_valid_i && mode_i == 2'd1 && exp_upd() && failb && !r_halt) begin
        r_vl = inc ? ((int'(step_i) + 1 > 127) ? 127 : int'(step_i) + 1) : int'(step_i);
        r_halt = 1'b1;
        r_trunc = 1'b1;
      end
    end
  end

  task automatic chk(string req, int got, int exp, string what);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, got, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (live) begin
      chk((cur_req == "R7" || cur_req == "R1") ? cur_req : "R6", int'(trunc_o), int'(r_trunc), "trunc_o");
      chk(cur_req, int'(vl_o), r_vl, "vl_o");
    end
  end

  task automatic cfg(logic [1:0] md, logic iv, logic [1:0] sl, logic o1, logic ic, logic rc, logic [1:0] kd);
    mode_i = md; inv_i = iv; crsel_i = sl; rc1_i = o1; incl_i = ic; rc_i = rc; rc_kind_i = kd;
  endtask

  task automatic drive(logic st, logic [6:0] vl, logic ev, logic [6:0] stp, logic [3:0] cf);
    @(negedge clk);
    start_i = st; vl_i = vl; elem_valid_i = ev; step_i = stp; crf_i = cf;
    #1;
    chk("R2", int'(crupd_o), int'(exp_upd()), "crupd_o");
  endtask

  task automatic idle();
    drive(1'b0, 7'd0, 1'b0, 7'd0, 4'd0);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9", int'(vl_o), 0, "vl_o in reset");
    chk("R9", int'(trunc_o), 0, "trunc_o in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", int'(vl_o), 0, "vl_o after reset");
    live = 1'b1;

    // R7: load and hold
    cur_req = "R7";
    cfg(2'd1, 0, 2'd0, 0, 0, 1, 2'd1);
    drive(1, 7'd40, 0, 0, 0);
    idle(); chk("R7", int'(vl_o), 40, "loaded length");
    idle(); idle(); chk("R7", int'(vl_o), 40, "held length");

    // R3/R5: Rc=1, select bit 0, plain sense
    cur_req = "R3";
    for (int s = 0; s < 4; s++) drive(0, 0, 1, 7'(s), 4'b1110);
    drive(0, 0, 1, 7'd4, 4'b0001);
    idle(); chk("R3", int'(vl_o), 4, "truncated at step 4");
    // R8: later failing element ignored
    cur_req = "R8";
    drive(0, 0, 1, 7'd5, 4'b1111);
    idle(); chk("R8", int'(vl_o), 4, "post-halt element ignored");

    // R5 inverted sense, select bit 1, incl ignored with Rc=1
    cur_req = "R5";
    cfg(2'd1, 1, 2'd1, 1, 1, 1, 2'd1);
    drive(1, 7'd30, 0, 0, 0);
    drive(0, 0, 1, 7'd0, 4'b0010);
    drive(0, 0, 1, 7'd1, 4'b1111);
    drive(0, 0, 1, 7'd2, 4'b0010);
    drive(0, 0, 1, 7'd3, 4'b1101);
    idle(); chk("R5", int'(vl_o), 3, "inverted fail, exclusive");

    // R4: Rc=0 with override, equality bit implicit, inclusive
    cur_req = "R4";
    cfg(2'd1, 0, 2'd0, 1, 1, 0, 2'd1);
    drive(1, 7'd20, 0, 0, 0);
    drive(0, 0, 1, 7'd5, 4'b1011);
    idle(); chk("R4", int'(vl_o), 20, "bit 2 clear, no fail");
    drive(0, 0, 1, 7'd6, 4'b0100);
    idle(); chk("R4", int'(vl_o), 7, "inclusive length");

    // R1: non fail-first mode
    cur_req = "R1";
    cfg(2'd2, 0, 2'd0, 0, 0, 1, 2'd1);
    drive(1, 7'd50, 0, 0, 0);
    drive(0, 0, 1, 7'd2, 4'b1111);
    idle(); chk("R1", int'(vl_o), 50, "other mode no truncation");
    cfg(2'd1, 0, 2'd0, 0, 0, 0, 2'd1);
    drive(0, 0, 1, 7'd3, 4'b1111);
    idle(); chk("R1", int'(vl_o), 50, "no update enable");

    // R2: kinds
    cur_req = "R2";
    cfg(2'd1, 0, 2'd0, 1, 0, 0, 2'd0);
    drive(0, 0, 1, 7'd4, 4'b0100);
    idle(); chk("R2", int'(vl_o), 50, "kind none ignores override");
    cfg(2'd1, 0, 2'd0, 1, 0, 1, 2'd2);
    drive(0, 0, 1, 7'd9, 4'b0100);
    idle(); chk("R2", int'(vl_o), 9, "forced kind with override");
    cfg(2'd1, 0, 2'd0, 0, 0, 1, 2'd2);
    drive(1, 7'd60, 0, 0, 0);
    drive(0, 0, 1, 7'd1, 4'b0100);
    idle(); chk("R2", int'(vl_o), 60, "forced kind, no override");

    // R6: saturation and invalid elements
    cur_req = "R6";
    cfg(2'd1, 0, 2'd0, 1, 1, 0, 2'd1);
    drive(1, 7'd127, 0, 0, 0);
    drive(0, 0, 0, 7'd3, 4'b0100);
    idle(); chk("R6", int'(vl_o), 127, "invalid element ignored");
    drive(0, 0, 1, 7'd127, 4'b0100);
    #1 chk("R6", int'(trunc_o), 0, "strobe not before edge");
    idle(); chk("R6", int'(trunc_o), 1, "strobe one cycle later");
    chk("R6", int'(vl_o), 127, "saturated length");

    // R8: start wins over element
    cur_req = "R8";
    drive(1, 7'd33, 1, 7'd2, 4'b0100);
    idle(); chk("R8", int'(vl_o), 33, "start priority");
    chk("R8", int'(trunc_o), 0, "no strobe on start");

    // randomized run, model comparison each clock
    cur_req = "R6";
    begin
      int stp = 0;
      for (int i = 0; i < 3000; i++) begin
        bit st = ($urandom_range(0, 19) == 0);
        cfg(2'($urandom_range(0, 3)), 1'($urandom), 2'($urandom), 1'($urandom),
            1'($urandom), 1'($urandom), 2'($urandom_range(0, 3)));
        if (($urandom_range(0, 3) != 0)) mode_i = 2'd1;
        if (st) stp = 0;
        drive(st, 7'($urandom), 1'($urandom_range(0, 3) != 0), 7'(stp), 4'($urandom));
        if (elem_valid_i) stp = (stp + 1) % 128;
      end
    end
    idle(); idle();
    live = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule